// File: doc/BRIEF.md
# Rectangle Transfer Engine for a Pixel Frame Store

This block moves a rectangle of 16-bit pixels between a 32-bit host word port and a two-dimensional pixel store. It also copies one rectangle of that store to another place in it. A command gives a kind, a start position word, a size word and, for copies, a destination position word. The engine then walks the rectangle row by row and produces one pixel address for each pixel. Column and row indices wrap at the edges of the store.

Host writes accept one word per cycle while `wr_valid` is high. Each word carries two pixels, and the low half is the earlier pixel. Host reads return one word in the cycle after each `rd_req`. The host may stop the stream at any word and continue later. The position is kept exactly, even in the middle of a row.

Copies work one row at a time. The engine loads the whole source row into a line buffer before it stores any of that row at the destination, so overlapping rectangles copy the original contents. An optional mask flag forces bit 15 of every pixel the engine writes. In the full chip the geometry parameters select a 1024 by 512 store. The defaults are smaller so that the modelled RAM stays small.

Top module: `vram_xfer`

## Requirements
- R1: A command is taken only when `cmd_valid` is high and `busy` is low. `cmd_kind` 0 is a host write, 1 is a host read, 2 is a copy, and 3 is ignored. A command presented while `busy` is high has no effect.
- R2: The start column comes from bits XW-1:0 of the position word and the start row from bits 16+YW-1:16. All other bits of the position word are ignored.
- R3: Width is ((size[XW-1:0] - 1) mod 2^XW) + 1 and height is ((size[16+YW-1:16] - 1) mod 2^YW) + 1. A zero field therefore means the full extent.
- R4: Pixels fill a row from left to right, and then the next row down starts at the start column. In each host word, bits 15:0 hold the earlier pixel and bits 31:16 the later one.
- R5: The column index wraps modulo 2^XW and the row index wraps modulo 2^YW.
- R6: When `force_mask` is high at command acceptance, every pixel that the command writes has bit 15 set. This applies to host writes and to copies.
- R7: A copy whose decoded source and destination positions are equal, taken with `force_mask` low, writes nothing. It raises `done` in the next cycle while `busy` stays low.
- R8: A copy reads a whole source row before it writes any pixel of the matching destination row. A copy that shifts a row to the right over itself therefore reproduces the original pixels.
- R9: `img_ready` rises in the cycle after a read command is taken and falls when the last pixel of that read has been returned.
- R10: Idle cycles between host words, in either direction, leave the transfer position unchanged.
- R11: `done` is a one-cycle pulse on the same edge at which `busy` falls. `rd_valid` and `rd_data` appear in the cycle after an accepted `rd_req`.
- R12: When the pixel count is odd, the upper half of the final word is discarded on a write and returned as zero on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_kind | input | 2 | 0 write, 1 read, 2 copy, 3 none |
| cmd_pos | input | 32 | Start (source) position word |
| cmd_size | input | 32 | Size word |
| cmd_dst | input | 32 | Copy destination position word |
| force_mask | input | 1 | Force pixel bit 15 on writes, sampled at acceptance |
| wr_valid | input | 1 | Host write word present |
| wr_data | input | 32 | Host write word, two pixels |
| rd_req | input | 1 | Host read word request |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word, two pixels |
| busy | output | 1 | Transfer in progress |
| img_ready | output | 1 | Read transfer open |
| done | output | 1 | Transfer finished pulse |

## Verification
A wrong column offset, row or remaining-row count inside the engine does not show at once. It shows on the first later read word whose pixel value differs, or as `busy` and `done` falling a word early or late. The reference model predicts `busy`, `img_ready`, `done`, `rd_valid` and every returned word on each cycle, so a position error is reported at the first read word it reaches. A wrong copy row order or a missing mask bit is reported on the first read-back of the affected pixels.

// File: rtl/vram_xfer_pkg.sv
package vram_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_CPLOAD,
    ST_CPSTORE
  } xfer_state_e;

  localparam logic [1:0] KIND_WR = 2'd0;
  localparam logic [1:0] KIND_RD = 2'd1;
  localparam logic [1:0] KIND_CP = 2'd2;

  localparam logic [15:0] PIX_MSB = 16'h8000;

  // extent of a field of 'bits' bits: zero maps to the full range
  function automatic logic [15:0] extent(input logic [15:0] field, input int bits);
    logic [15:0] m;
    m = 16'((32'd1 << bits) - 32'd1);
    return ((field - 16'd1) & m) + 16'd1;
  endfunction

  function automatic logic [15:0] apply_mask(input logic [15:0] pix, input logic on);
    return on ? (pix | PIX_MSB) : pix;
  endfunction

endpackage

// File: rtl/vram_xfer_ram.sv
module vram_xfer_ram #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rq0,
  output logic [DW-1:0] rq1,
  input  logic          we0,
  input  logic [AW-1:0] wa0,
  input  logic [DW-1:0] wd0,
  input  logic          we1,
  input  logic [AW-1:0] wa1,
  input  logic [DW-1:0] wd1
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first synchronous RAM with two read and two write ports
  always_ff @(posedge clk) begin
    rq0 <= mem[ra0];
    rq1 <= mem[ra1];
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end
endmodule

// File: rtl/vram_xfer_linebuf.sv
module vram_xfer_linebuf #(
  parameter int XW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [XW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [XW-1:0] ra,
  output logic [DW-1:0] rq
);
  localparam int DEPTH = 1 << XW;

  logic [DW-1:0] row [DEPTH];

  always_ff @(posedge clk) begin
    if (we) row[wa] <= wd;
  end

  assign rq = row[ra];
endmodule

// File: rtl/vram_xfer.sv
module vram_xfer
  import vram_xfer_pkg::*;
#(
  parameter int XW = 6,
  parameter int YW = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_kind,
  input  logic [31:0] cmd_pos,
  input  logic [31:0] cmd_size,
  input  logic [31:0] cmd_dst,
  input  logic        force_mask,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  input  logic        rd_req,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        busy,
  output logic        img_ready,
  output logic        done
);
  localparam int AW = XW + YW;
  localparam logic [XW:0] ONE_X = (XW+1)'(1);
  localparam logic [YW:0] ONE_Y = (YW+1)'(1);

  xfer_state_e   st;
  logic [XW-1:0] sx, dx, off;
  logic [YW-1:0] sy, dy;
  logic [XW:0]   wid, cnt;
  logic [YW:0]   left;
  logic          mask_r;
  logic          rd_hi_void_q;

  // command decode
  logic [XW-1:0] c_x, c_dx;
  logic [YW-1:0] c_y, c_dy;
  logic [XW:0]   c_w;
  logic [YW:0]   c_h;
  assign c_x  = cmd_pos[XW-1:0];
  assign c_y  = cmd_pos[16 +: YW];
  assign c_dx = cmd_dst[XW-1:0];
  assign c_dy = cmd_dst[16 +: YW];
  assign c_w  = (XW+1)'(extent(16'(cmd_size[XW-1:0]), XW));
  assign c_h  = (YW+1)'(extent(16'(cmd_size[16 +: YW]), YW));

  logic accept, copy_noop;
  assign accept    = cmd_valid && (st == ST_IDLE);
  assign copy_noop = accept && (cmd_kind == KIND_CP) && (c_x == c_dx)
                     && (c_y == c_dy) && !force_mask;

  // host walker: positions of the two pixels of a word and the one after
  logic          end_a, end_b;
  logic [XW-1:0] off_b, off_c;
  logic [YW-1:0] row_b, row_c;
  logic [YW:0]   left_b, left_c;
  assign end_a  = ({1'b0, off} + ONE_X) == wid;
  assign off_b  = end_a ? '0 : off + XW'(1);
  assign row_b  = end_a ? sy + YW'(1) : sy;
  assign left_b = end_a ? left - ONE_Y : left;
  assign end_b  = ({1'b0, off_b} + ONE_X) == wid;
  assign off_c  = end_b ? '0 : off_b + XW'(1);
  assign row_c  = end_b ? row_b + YW'(1) : row_b;
  assign left_c = end_b ? left_b - ONE_Y : left_b;

  logic [AW-1:0] addr_a, addr_b;
  assign addr_a = {sy, sx + off};
  assign addr_b = {row_b, sx + off_b};

  // named events for the checker
  logic wr_fire, rd_fire, rd_hi_void, host_last, cp_last, xfer_last;
  assign wr_fire    = (st == ST_WR) && wr_valid;
  assign rd_fire    = (st == ST_RD) && rd_req;
  assign rd_hi_void = (left_b == '0);
  assign host_last  = (wr_fire || rd_fire) && (rd_hi_void || (left_c == '0));
  assign cp_last    = (st == ST_CPSTORE) && (cnt == wid - ONE_X) && (left == ONE_Y);
  assign xfer_last  = host_last || cp_last;

  // memory and line buffer hookup
  logic [AW-1:0] ra0, wa0;
  logic          we0, we1;
  logic [15:0]   wd0, wd1, rq0, rq1, lb_q;
  logic          lb_we;

  assign ra0   = (st == ST_CPLOAD) ? {sy, sx + cnt[XW-1:0]} : addr_a;
  assign we0   = wr_fire || (st == ST_CPSTORE);
  assign wa0   = (st == ST_CPSTORE) ? {dy, dx + cnt[XW-1:0]} : addr_a;
  assign wd0   = apply_mask((st == ST_CPSTORE) ? lb_q : wr_data[15:0], mask_r);
  assign we1   = wr_fire && !rd_hi_void;
  assign wd1   = apply_mask(wr_data[31:16], mask_r);
  assign lb_we = (st == ST_CPLOAD) && (cnt != '0);

  vram_xfer_ram #(.AW(AW), .DW(16)) u_ram (
    .clk (clk),
    .ra0 (ra0),
    .ra1 (addr_b),
    .rq0 (rq0),
    .rq1 (rq1),
    .we0 (we0),
    .wa0 (wa0),
    .wd0 (wd0),
    .we1 (we1),
    .wa1 (addr_b),
    .wd1 (wd1)
  );

  vram_xfer_linebuf #(.XW(XW), .DW(16)) u_line (
    .clk (clk),
    .we  (lb_we),
    .wa  (cnt[XW-1:0] - XW'(1)),
    .wd  (rq0),
    .ra  (cnt[XW-1:0]),
    .rq  (lb_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      sx           <= '0;
      sy           <= '0;
      dx           <= '0;
      dy           <= '0;
      off          <= '0;
      wid          <= '0;
      cnt          <= '0;
      left         <= '0;
      mask_r       <= 1'b0;
      img_ready    <= 1'b0;
      done         <= 1'b0;
      rd_valid     <= 1'b0;
      rd_hi_void_q <= 1'b0;
    end else begin
      done     <= xfer_last || copy_noop;
      rd_valid <= rd_fire;
      if (rd_fire) rd_hi_void_q <= rd_hi_void;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            sx     <= c_x;
            sy     <= c_y;
            dx     <= c_dx;
            dy     <= c_dy;
            wid    <= c_w;
            left   <= c_h;
            off    <= '0;
            cnt    <= '0;
            mask_r <= force_mask;
            case (cmd_kind)
              KIND_WR: st <= ST_WR;
              KIND_RD: begin
                st        <= ST_RD;
                img_ready <= 1'b1;
              end
              KIND_CP: if (!copy_noop) st <= ST_CPLOAD;
              default: st <= ST_IDLE;
            endcase
          end
        end
        ST_WR, ST_RD: begin
          if (wr_fire || rd_fire) begin
            if (rd_hi_void) begin
              off  <= off_b;
              sy   <= row_b;
              left <= left_b;
            end else begin
              off  <= off_c;
              sy   <= row_c;
              left <= left_c;
            end
            if (host_last) begin
              st        <= ST_IDLE;
              img_ready <= 1'b0;
            end
          end
        end
        ST_CPLOAD: begin
          if (cnt == wid) begin
            cnt <= '0;
            st  <= ST_CPSTORE;
          end else begin
            cnt <= cnt + ONE_X;
          end
        end
        ST_CPSTORE: begin
          if (cnt == wid - ONE_X) begin
            cnt  <= '0;
            sy   <= sy + YW'(1);
            dy   <= dy + YW'(1);
            left <= left - ONE_Y;
            st   <= (left == ONE_Y) ? ST_IDLE : ST_CPLOAD;
          end else begin
            cnt <= cnt + ONE_X;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign rd_data = {rd_hi_void_q ? 16'h0000 : rq1, rq0};

endmodule

// File: rtl/vram_xfer_chk.sv
module vram_xfer_chk #(
  parameter int XW = 6,
  parameter int YW = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [1:0]  cmd_kind,
  input logic [31:0] cmd_pos,
  input logic [31:0] cmd_dst,
  input logic        force_mask,
  input logic        rd_req,
  input logic        rd_valid,
  input logic        busy,
  input logic        img_ready,
  input logic        done,
  input logic        xfer_last
);
  // R1
  ignored_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !img_ready && cmd_valid) |=> !img_ready);

  // R7
  copy_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_kind == 2'd2 && !force_mask
     && cmd_pos[XW-1:0] == cmd_dst[XW-1:0]
     && cmd_pos[16 +: YW] == cmd_dst[16 +: YW]) |=> (done && !busy));

  // R9
  img_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(img_ready) |-> $past(cmd_valid && !busy && cmd_kind == 2'd1));

  // R9
  img_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready |-> busy);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !img_ready));

  // R11
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |=> done);

  // R11
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req && img_ready));
endmodule

bind vram_xfer vram_xfer_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_kind   (cmd_kind),
  .cmd_pos    (cmd_pos),
  .cmd_dst    (cmd_dst),
  .force_mask (force_mask),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .busy       (busy),
  .img_ready  (img_ready),
  .done       (done),
  .xfer_last  (xfer_last)
);

// File: tb/vram_xfer_bench.sv
module vram_xfer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 64;
  localparam int ROWS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic [31:0] cmd_pos = '0, cmd_size = '0, cmd_dst = '0;
  logic        force_mask = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic        rd_valid, busy, img_ready, done;
  logic [31:0] rd_data;

  vram_xfer u_vram_xfer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_pos(cmd_pos), .cmd_size(cmd_size), .cmd_dst(cmd_dst),
    .force_mask(force_mask), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .img_ready(img_ready), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  string cur_tag = "R4";
  logic [31:0] got[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] mm [COLS*ROWS];
  logic [15:0] mbuf [COLS];
  int ms = 0, mx0 = 0, my = 0, moff = 0, mw = 1, mleft = 0, mdx = 0, mdy = 0, mcnt = 0;
  logic [15:0] mk = 16'h0;
  logic exp_busy = 0, exp_img = 0, exp_done = 0, exp_rv = 0;
  logic [31:0] exp_rd = '0;

  function automatic int maddr(input int x, input int y);
    return (y % ROWS) * COLS + (x % COLS);
  endfunction

  function automatic void madv();
    moff++;
    if (moff == mw) begin
      moff = 0;
      my = (my + 1) % ROWS;
      mleft--;
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; exp_img = 0; exp_done = 0; exp_rv = 0;
    end else begin
      exp_done = 0;
      exp_rv = 0;
      case (ms)
        0: if (cmd_valid) begin
          mx0 = cmd_pos & (COLS-1);
          my = (cmd_pos >> 16) & (ROWS-1);
          mdx = cmd_dst & (COLS-1);
          mdy = (cmd_dst >> 16) & (ROWS-1);
          mw = (((cmd_size & (COLS-1)) - 1) & (COLS-1)) + 1;
          mleft = ((((cmd_size >> 16) & (ROWS-1)) - 1) & (ROWS-1)) + 1;
          moff = 0; mcnt = 0;
          mk = force_mask ? 16'h8000 : 16'h0;
          if (cmd_kind == 0) ms = 1;
          else if (cmd_kind == 1) begin ms = 2; exp_img = 1; end
          else if (cmd_kind == 2) begin
            if (mx0 == mdx && my == mdy && !force_mask) exp_done = 1;
            else ms = 3;
          end
        end
        1: if (wr_valid) begin
          mm[maddr(mx0 + moff, my)] = wr_data[15:0] | mk;
          madv();
          if (mleft > 0) begin
            mm[maddr(mx0 + moff, my)] = wr_data[31:16] | mk;
            madv();
          end
          if (mleft == 0) begin exp_done = 1; ms = 0; end
        end
        2: if (rd_req) begin
          exp_rv = 1;
          exp_rd[15:0] = mm[maddr(mx0 + moff, my)];
          madv();
          if (mleft > 0) begin
            exp_rd[31:16] = mm[maddr(mx0 + moff, my)];
            madv();
          end else exp_rd[31:16] = 16'h0;
          if (mleft == 0) begin exp_done = 1; ms = 0; exp_img = 0; end
        end
        3: if (mcnt == mw) begin
          for (int i = 0; i < mw; i++) mbuf[i] = mm[maddr(mx0 + i, my)];
          mcnt = 0; ms = 4;
        end else mcnt++;
        4: begin
          mm[maddr(mdx + mcnt, mdy)] = mbuf[mcnt] | mk;
          if (mcnt == mw - 1) begin
            mcnt = 0;
            my = (my + 1) % ROWS;
            mdy = (mdy + 1) % ROWS;
            mleft--;
            if (mleft == 0) begin exp_done = 1; ms = 0; end
            else ms = 3;
          end else mcnt++;
        end
        default: ms = 0;
      endcase
      exp_busy = (ms != 0);
    end
  end

  // per-cycle comparison and read capture, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 busy", {31'b0, busy}, {31'b0, exp_busy});
      chk("R9 img_ready", {31'b0, img_ready}, {31'b0, exp_img});
      chk("R11 done", {31'b0, done}, {31'b0, exp_done});
      chk("R11 rd_valid", {31'b0, rd_valid}, {31'b0, exp_rv});
      if (exp_rv) chk({cur_tag, " rd_data"}, rd_data, exp_rd);
    end
    if (rd_valid) got.push_back(rd_data);
  end

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 7 + 3) & 32'h7fff);
  endfunction

  function automatic logic [31:0] pos(input int x, input int y);
    return (32'(y) << 16) | 32'(x);
  endfunction

  task automatic issue(input logic [1:0] k, input logic [31:0] p, input logic [31:0] s,
                       input logic [31:0] d, input logic m);
    cmd_valid = 1'b1; cmd_kind = k; cmd_pos = p; cmd_size = s; cmd_dst = d; force_mask = m;
    @(negedge clk);
    cmd_valid = 1'b0; force_mask = 1'b0;
  endtask

  task automatic send(input logic [31:0] w, input int gap);
    wr_valid = 1'b1; wr_data = w;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic fetch(input int n, input int gap);
    got.delete();
    repeat (n) begin
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      repeat (gap) @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000 - 50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    // reset state (R11, R1)
    chk("R1 reset busy", {31'b0, busy}, 32'd0);
    chk("R11 reset done", {31'b0, done}, 32'd0);
    chk("R9 reset img_ready", {31'b0, img_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: zero size fields cover the whole store
    cur_tag = "R3";
    issue(2'd0, pos(0, 0), 32'h0, 32'h0, 1'b0);
    for (int i = 0; i < COLS*ROWS/2 - 1; i++) send({pat(2*i+1), pat(2*i)}, 0);
    chk("R3 busy before last word", {31'b0, busy}, 32'd1);
    send({pat(COLS*ROWS-1), pat(COLS*ROWS-2)}, 0);
    chk("R3 done after last word", {31'b0, done}, 32'd1);
    chk("R11 busy falls with done", {31'b0, busy}, 32'd0);

    // R2, R4, R9: position bits outside the fields ignored, row order
    cur_tag = "R2";
    issue(2'd1, pos(5 | 64, 3 | 32), (32'd2 << 16) | 32'd3, 32'h0, 1'b0);
    chk("R9 img_ready after read accept", {31'b0, img_ready}, 32'd1);
    fetch(3, 0);
    chk("R2 first word", got[0], {pat(3*64+6), pat(3*64+5)});
    chk("R4 word crossing row end", got[1], {pat(4*64+5), pat(3*64+7)});
    chk("R9 img_ready after last word", {31'b0, img_ready}, 32'd0);

    // R12: odd read count
    cur_tag = "R12";
    issue(2'd1, pos(5, 3), (32'd1 << 16) | 32'd3, 32'h0, 1'b0);
    fetch(2, 0);
    chk("R12 read upper half zero", got[1], {16'h0, pat(3*64+7)});

    // R5: wrap in both axes
    cur_tag = "R5";
    issue(2'd0, pos(62, 31), (32'd2 << 16) | 32'd4, 32'h0, 1'b0);
    for (int k = 0; k < 4; k++) send({16'(16'h1112 + 2*k), 16'(16'h1111 + 2*k)}, 0);
    issue(2'd1, pos(0, 0), (32'd1 << 16) | 32'd2, 32'h0, 1'b0);
    fetch(1, 0);
    chk("R5 wrapped pixels", got[0], 32'h1118_1117);

    // R6: forced mask on host write
    cur_tag = "R6";
    issue(2'd0, pos(10, 10), (32'd1 << 16) | 32'd2, 32'h0, 1'b1);
    send(32'h0034_0012, 0);
    issue(2'd1, pos(10, 10), (32'd1 << 16) | 32'd2, 32'h0, 1'b0);
    fetch(1, 0);
    chk("R6 mask on write", got[0], 32'h8034_8012);

    // R7: copy onto itself without mask
    cur_tag = "R7";
    issue(2'd2, pos(20, 7), (32'd1 << 16) | 32'd1, pos(20, 7), 1'b0);
    chk("R7 noop done", {31'b0, done}, 32'd1);
    chk("R7 noop not busy", {31'b0, busy}, 32'd0);
    issue(2'd1, pos(20, 7), (32'd1 << 16) | 32'd1, 32'h0, 1'b0);
    fetch(1, 0);
    chk("R7 pixel unchanged", got[0], {16'h0, pat(7*64+20)});

    // R6: masked copy onto itself does write
    cur_tag = "R6";
    issue(2'd2, pos(20, 7), (32'd1 << 16) | 32'd1, pos(20, 7), 1'b1);
    wait_idle();
    issue(2'd1, pos(20, 7), (32'd1 << 16) | 32'd1, 32'h0, 1'b0);
    fetch(1, 0);
    chk("R6 mask on copy", got[0], {16'h0, pat(7*64+20) | 16'h8000});

    // R8: overlapping right shift copy
    cur_tag = "R8";
    issue(2'd2, pos(0, 5), (32'd2 << 16) | 32'd8, pos(2, 5), 1'b0);
    wait_idle();
    issue(2'd1, pos(2, 5), (32'd1 << 16) | 32'd8, 32'h0, 1'b0);
    fetch(4, 0);
    chk("R8 start of shifted row", got[0], {pat(5*64+1), pat(5*64+0)});
    chk("R8 end of shifted row", got[3], {pat(5*64+7), pat(5*64+6)});

    // R10, R12: paused stream with odd pixel count
    cur_tag = "R10";
    issue(2'd0, pos(30, 12), (32'd3 << 16) | 32'd5, 32'h0, 1'b0);
    for (int k = 0; k < 8; k++) send({16'(16'h2200 + 2*k + 1), 16'(16'h2200 + 2*k)}, k % 3);
    issue(2'd1, pos(30, 12), (32'd3 << 16) | 32'd5, 32'h0, 1'b0);
    fetch(8, 2);
    chk("R10 first word after pauses", got[0], 32'h2201_2200);
    chk("R10 mid word after pauses", got[3], 32'h2207_2206);
    chk("R12 last read word", got[7], 32'h0000_220e);
    cur_tag = "R12";
    issue(2'd1, pos(30, 15), (32'd1 << 16) | 32'd1, 32'h0, 1'b0);
    fetch(1, 0);
    chk("R12 discarded write half", got[0], {16'h0, pat(15*64+30)});

    // R1: commands while busy and the unused kind are ignored
    cur_tag = "R1";
    issue(2'd0, pos(40, 20), (32'd1 << 16) | 32'd2, 32'h0, 1'b0);
    issue(2'd1, pos(1, 1), (32'd1 << 16) | 32'd1, 32'h0, 1'b0);
    chk("R1 read while busy ignored", {31'b0, img_ready}, 32'd0);
    send(32'h0abc_0def, 0);
    chk("R1 write completed", {31'b0, busy}, 32'd0);
    issue(2'd3, pos(1, 1), 32'h0, 32'h0, 1'b0);
    chk("R1 unused kind ignored", {31'b0, busy}, 32'd0);
    issue(2'd1, pos(40, 20), (32'd1 << 16) | 32'd2, 32'h0, 1'b0);
    fetch(1, 0);
    chk("R1 write data intact", got[0], 32'h0abc_0def);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule